// File: doc/BRIEF.md
# UART Sleep and Wake-Up Controller

This block sits beside a UART core and decides when the core's internal clocks may be switched off. It watches the serial input, the FIFO and shift-register status, pending interrupts, the modem input pins and TX FIFO write strobes. When the datapath is quiet and sleep is enabled for the current mode family, it drops the clock-gate enable. Any qualifying activity brings the enable back. The enable rises in the same cycle as the event, so the gated domain plays no part in its own restart.

Two mode families are supported: a UART/modem family and an infrared family. They differ in which register bit enables sleep and in whether modem pin changes count as activity. A sticky wake-up interrupt can report events that happen while the block is asleep. This interrupt stays outside the core's normal interrupt identification. Software clears it by turning off its enable.

The block also answers a system idle request. Once it acknowledges, it stops passing interrupt and DMA requests through. It then reports only the events left unmasked in its wake mask, as single-cycle wake pulses. All pins are plain control and status levels. There is no streaming interface, so no valid/ready back-pressure applies. Everything runs on one always-on clock.

Top module: `uart_pm_ctrl`

## Requirements
- R1: Sleep is permitted in the UART family (mode_ir=0) only when cfg_enh_en and cfg_uart_sleep_en are both 1. In the infrared family (mode_ir=1) it is permitted only when cfg_ir_sleep_en is 1. The other family's enable bit has no effect.
- R2: The block sleeps (clk_en=0) only when all of these hold: the RX line is idle, tx_fifo_empty=1, tx_shift_empty=1, rx_fifo_empty=1 and irq_pending_other=0. It enters sleep on the clock edge after these conditions and the enable all hold.
- R3: rx_in passes through a two-flop synchronizer. The line is idle only after the synchronized value has been 1 for CHAR_CYCLES consecutive clocks.
- R4: In the UART family, any of these ends sleep: an RX transition, a tx_fifo_wr strobe, or any change on modem_in. clk_en goes high combinationally in the cycle the event is seen, and the state returns to active on the next edge.
- R5: In the infrared family, changes on modem_in do not wake the block and do not set the wake interrupt.
- R6: When cfg_wake_irq_en=1, a wake event seen while asleep sets wake_irq on the next edge. wake_irq then stays 1 until cfg_wake_irq_en is 0 at a clock edge, after which it reads 0.
- R7: With cfg_tx_wake_en=1, three TX sources also count as wake events. A THR interrupt counts if thr_irq_en=1, but not when tx_dma_en=1, and not in the infrared family when tx_stat_irq_en=1. A TX DMA request counts if tx_dma_en=1. A TX status interrupt counts if tx_stat_irq_en=1, in the infrared family only.
- R8: idle_ack rises only when all of these hold: idle_req=1, the R2 quiet conditions hold, and core_irq=0 and core_dma_req=0. While idle_ack=1, irq_out and dma_out are 0. Otherwise they follow core_irq and core_dma_req.
- R9: idle_ack falls on the first clock edge at which idle_req is 0.
- R10: While cfg_div_access=1, sleep is not permitted and a sleeping block wakes.
- R11: While idle is acknowledged, wake_out pulses for one cycle, one edge after an event that is unmasked. cfg_wake_mask bit 0 unmasks RX transitions, bit 1 unmasks modem changes and bit 2 unmasks TX FIFO writes. The R7 TX sources are always unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_ir | input | 1 | 1 selects the infrared family |
| cfg_enh_en | input | 1 | Enhanced-feature enable qualifying UART sleep |
| cfg_uart_sleep_en | input | 1 | Sleep enable for the UART family |
| cfg_ir_sleep_en | input | 1 | Sleep enable for the infrared family |
| cfg_div_access | input | 1 | Divisor latch access in progress |
| cfg_wake_irq_en | input | 1 | Wake interrupt enable; 0 clears wake_irq |
| cfg_tx_wake_en | input | 1 | Lets TX sources raise wake events |
| cfg_wake_mask | input | 3 | Unmask bits for idle-mode wakeups (rx, modem, tx write) |
| rx_in | input | 1 | Asynchronous serial input line |
| modem_in | input | MODEM_W | Asynchronous modem input pins |
| tx_fifo_wr | input | 1 | TX FIFO write strobe |
| tx_fifo_empty | input | 1 | TX FIFO empty |
| tx_shift_empty | input | 1 | TX shift register empty |
| rx_fifo_empty | input | 1 | RX FIFO empty |
| irq_pending_other | input | 1 | A non-THR interrupt is pending |
| thr_irq_en | input | 1 | THR interrupt enabled |
| thr_irq | input | 1 | THR interrupt raised |
| tx_dma_en | input | 1 | TX DMA enabled |
| tx_dma_req | input | 1 | TX DMA request raised |
| tx_stat_irq_en | input | 1 | TX status interrupt enabled |
| tx_stat_irq | input | 1 | TX status interrupt raised |
| core_irq | input | 1 | Raw interrupt request from the core |
| core_dma_req | input | 1 | Raw DMA request from the core |
| idle_req | input | 1 | System idle request |
| clk_en | output | 1 | Clock-gate enable for module and baud clocks |
| wake_irq | output | 1 | Sticky wake-up interrupt and status flag |
| idle_ack | output | 1 | Idle acknowledge |
| wake_out | output | 1 | Wakeup pulse while idle is acknowledged |
| irq_out | output | 1 | Qualified interrupt request |
| dma_out | output | 1 | Qualified DMA request |

## Verification
The bench drives each sleep-entry condition false on its own and swaps the enable bits across the two families. A design that left out one condition, or read the wrong family's enable, would gate clocks while data was still pending. It times the RX idle window after a line pulse, which catches a design that sleeps again before a full character of idle. It aims at the sticky wake flag and its clear-by-disable rule, at modem changes in infrared mode, and at THR events when DMA is enabled. A wrong design would leave a flag set or raise wakes the rules forbid. The idle handshake is tried with a request in flight and with non-empty FIFOs, then released. This exposes early acknowledges, leaked interrupt requests and a late drop of the acknowledge.

// File: rtl/uart_pm_pkg.sv
package uart_pm_pkg;

  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_SLEEP  = 2'd1,
    PM_IDLE   = 2'd2
  } pm_state_e;

  localparam int WMASK_W  = 3;
  localparam int WM_RX    = 0;
  localparam int WM_MODEM = 1;
  localparam int WM_TXWR  = 2;

  typedef struct packed {
    logic rx;
    logic modem;
    logic tx_wr;
    logic tx_src;
  } pm_evt_t;

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int W       = 1,
  parameter bit RST_ONE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] RST_V = {W{RST_ONE}};
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_V;
      q  <= RST_V;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/pm_rx_idle.sv
module pm_rx_idle #(
  parameter int CHAR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_s,
  output logic rx_idle,
  output logic rx_chg
);
  localparam int CNT_W = $clog2(CHAR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CHAR_CYCLES);

  logic [CNT_W-1:0] cnt;
  logic             rx_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      rx_prev <= 1'b1;
    end else begin
      rx_prev <= rx_s;
      if (!rx_s)               cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

  assign rx_idle = (cnt == CNT_MAX);
  assign rx_chg  = rx_s ^ rx_prev;
endmodule

// File: rtl/pm_wake_src.sv
module pm_wake_src
  import uart_pm_pkg::*;
#(
  parameter int MODEM_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_ir,
  input  logic               rx_chg,
  input  logic               tx_fifo_wr,
  input  logic [MODEM_W-1:0] modem_s,
  input  logic               cfg_tx_wake_en,
  input  logic               thr_irq_en,
  input  logic               thr_irq,
  input  logic               tx_dma_en,
  input  logic               tx_dma_req,
  input  logic               tx_stat_irq_en,
  input  logic               tx_stat_irq,
  input  logic [WMASK_W-1:0] cfg_wake_mask,
  output logic               activity,
  output logic               masked_evt
);
  logic [MODEM_W-1:0] modem_prev;
  logic               thr_src, dma_src, stat_src;
  pm_evt_t            evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) modem_prev <= '0;
    else        modem_prev <= modem_s;
  end

  always_comb begin
    thr_src    = thr_irq_en & ~tx_dma_en & ~(mode_ir & tx_stat_irq_en) & thr_irq;
    dma_src    = tx_dma_en & tx_dma_req;
    stat_src   = mode_ir & tx_stat_irq_en & tx_stat_irq;
    evt.rx     = rx_chg;
    evt.modem  = ~mode_ir & (|(modem_s ^ modem_prev));
    evt.tx_wr  = tx_fifo_wr;
    evt.tx_src = cfg_tx_wake_en & (thr_src | dma_src | stat_src);
    activity   = |evt;
    masked_evt = (cfg_wake_mask[WM_RX]    & evt.rx)
               | (cfg_wake_mask[WM_MODEM] & evt.modem)
               | (cfg_wake_mask[WM_TXWR]  & evt.tx_wr)
               | evt.tx_src;
  end
endmodule

// File: rtl/pm_power_fsm.sv
module pm_power_fsm
  import uart_pm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_ok,
  input  logic quiet,
  input  logic activity,
  input  logic masked_evt,
  input  logic idle_req,
  input  logic core_irq,
  input  logic core_dma_req,
  input  logic cfg_wake_irq_en,
  output logic clk_en,
  output logic idle_ack,
  output logic wake_irq,
  output logic wake_out,
  output logic irq_out,
  output logic dma_out
);
  pm_state_e state, state_d;
  logic      req_busy, wake_evt, flag_q, wout_q;

  assign req_busy = core_irq | core_dma_req;

  always_comb begin
    state_d = state;
    case (state)
      PM_ACTIVE: begin
        if (idle_req && quiet && !req_busy && !activity) state_d = PM_IDLE;
        else if (sleep_ok && !activity)                  state_d = PM_SLEEP;
      end
      PM_SLEEP: begin
        if (activity || !sleep_ok)   state_d = PM_ACTIVE;
        else if (idle_req && !req_busy) state_d = PM_IDLE;
      end
      PM_IDLE: begin
        if (!idle_req) state_d = PM_ACTIVE;
      end
      default: state_d = PM_ACTIVE;
    endcase
  end

  assign wake_evt = ((state == PM_SLEEP) & activity) | ((state == PM_IDLE) & masked_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PM_ACTIVE;
      flag_q <= 1'b0;
      wout_q <= 1'b0;
    end else begin
      state  <= state_d;
      flag_q <= cfg_wake_irq_en & (flag_q | wake_evt);
      wout_q <= (state == PM_IDLE) & masked_evt;
    end
  end

  assign clk_en   = (state == PM_ACTIVE) | ((state == PM_SLEEP) & activity);
  assign idle_ack = (state == PM_IDLE);
  assign wake_irq = flag_q;
  assign wake_out = wout_q;
  assign irq_out  = core_irq     & (state != PM_IDLE);
  assign dma_out  = core_dma_req & (state != PM_IDLE);
endmodule

// File: rtl/uart_pm_ctrl.sv
module uart_pm_ctrl
  import uart_pm_pkg::*;
#(
  parameter int CHAR_CYCLES = 16,
  parameter int MODEM_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_ir,
  input  logic               cfg_enh_en,
  input  logic               cfg_uart_sleep_en,
  input  logic               cfg_ir_sleep_en,
  input  logic               cfg_div_access,
  input  logic               cfg_wake_irq_en,
  input  logic               cfg_tx_wake_en,
  input  logic [WMASK_W-1:0] cfg_wake_mask,
  input  logic               rx_in,
  input  logic [MODEM_W-1:0] modem_in,
  input  logic               tx_fifo_wr,
  input  logic               tx_fifo_empty,
  input  logic               tx_shift_empty,
  input  logic               rx_fifo_empty,
  input  logic               irq_pending_other,
  input  logic               thr_irq_en,
  input  logic               thr_irq,
  input  logic               tx_dma_en,
  input  logic               tx_dma_req,
  input  logic               tx_stat_irq_en,
  input  logic               tx_stat_irq,
  input  logic               core_irq,
  input  logic               core_dma_req,
  input  logic               idle_req,
  output logic               clk_en,
  output logic               wake_irq,
  output logic               idle_ack,
  output logic               wake_out,
  output logic               irq_out,
  output logic               dma_out
);
  logic               rx_s, rx_idle, rx_chg;
  logic [MODEM_W-1:0] modem_s;
  logic               activity, masked_evt;
  logic               sleep_en, quiet, sleep_ok;

  pm_sync #(.W(1), .RST_ONE(1'b1)) u_rx_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s)
  );

  pm_sync #(.W(MODEM_W), .RST_ONE(1'b0)) u_modem_sync (
    .clk(clk), .rst_n(rst_n), .d(modem_in), .q(modem_s)
  );

  pm_rx_idle #(.CHAR_CYCLES(CHAR_CYCLES)) u_rx_idle (
    .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .rx_idle(rx_idle), .rx_chg(rx_chg)
  );

  pm_wake_src #(.MODEM_W(MODEM_W)) u_wake_src (
    .clk(clk), .rst_n(rst_n), .mode_ir(mode_ir), .rx_chg(rx_chg),
    .tx_fifo_wr(tx_fifo_wr), .modem_s(modem_s), .cfg_tx_wake_en(cfg_tx_wake_en),
    .thr_irq_en(thr_irq_en), .thr_irq(thr_irq), .tx_dma_en(tx_dma_en),
    .tx_dma_req(tx_dma_req), .tx_stat_irq_en(tx_stat_irq_en),
    .tx_stat_irq(tx_stat_irq), .cfg_wake_mask(cfg_wake_mask),
    .activity(activity), .masked_evt(masked_evt)
  );

  assign sleep_en = (mode_ir ? cfg_ir_sleep_en : (cfg_uart_sleep_en & cfg_enh_en))
                  & ~cfg_div_access;
  assign quiet    = rx_idle & tx_fifo_empty & tx_shift_empty & rx_fifo_empty
                  & ~irq_pending_other;
  assign sleep_ok = sleep_en & quiet;

  pm_power_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_ok(sleep_ok), .quiet(quiet),
    .activity(activity), .masked_evt(masked_evt), .idle_req(idle_req),
    .core_irq(core_irq), .core_dma_req(core_dma_req),
    .cfg_wake_irq_en(cfg_wake_irq_en), .clk_en(clk_en), .idle_ack(idle_ack),
    .wake_irq(wake_irq), .wake_out(wake_out), .irq_out(irq_out), .dma_out(dma_out)
  );
endmodule

// File: rtl/uart_pm_ctrl_chk.sv
module uart_pm_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_ir,
  input logic cfg_enh_en,
  input logic cfg_uart_sleep_en,
  input logic cfg_div_access,
  input logic cfg_wake_irq_en,
  input logic tx_fifo_empty,
  input logic tx_shift_empty,
  input logic rx_fifo_empty,
  input logic irq_pending_other,
  input logic idle_req,
  input logic clk_en,
  input logic idle_ack,
  input logic wake_irq,
  input logic wake_out,
  input logic irq_out,
  input logic dma_out
);
  AST_UART_SLEEP_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !idle_ack && !$past(mode_ir)) |-> $past(cfg_enh_en && cfg_uart_sleep_en)); // R1
  AST_SLEEP_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !idle_ack) |-> $past(tx_fifo_empty && tx_shift_empty && rx_fifo_empty
                                     && !irq_pending_other)); // R2
  AST_WAKE_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wake_irq_en |=> !wake_irq); // R6
  AST_WAKE_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && cfg_wake_irq_en) |=> wake_irq); // R6
  AST_IDLE_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ack |-> (!irq_out && !dma_out)); // R8
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_req |=> !idle_ack); // R9
  AST_DIV_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !idle_ack) |-> !$past(cfg_div_access)); // R10
  AST_WAKE_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_out |-> $past(idle_ack)); // R11
endmodule

bind uart_pm_ctrl uart_pm_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_ir(mode_ir), .cfg_enh_en(cfg_enh_en),
  .cfg_uart_sleep_en(cfg_uart_sleep_en), .cfg_div_access(cfg_div_access),
  .cfg_wake_irq_en(cfg_wake_irq_en), .tx_fifo_empty(tx_fifo_empty),
  .tx_shift_empty(tx_shift_empty), .rx_fifo_empty(rx_fifo_empty),
  .irq_pending_other(irq_pending_other), .idle_req(idle_req), .clk_en(clk_en),
  .idle_ack(idle_ack), .wake_irq(wake_irq), .wake_out(wake_out),
  .irq_out(irq_out), .dma_out(dma_out)
);

// File: tb/uart_pm_ctrl_tb_top.sv
module uart_pm_ctrl_tb_top;
  localparam int CHAR = 16;
  localparam int MW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_ir = 0, cfg_enh_en = 0, cfg_uart_sleep_en = 0, cfg_ir_sleep_en = 0;
  logic cfg_div_access = 0, cfg_wake_irq_en = 0, cfg_tx_wake_en = 0;
  logic [2:0] cfg_wake_mask = 3'b000;
  logic rx_in = 1'b1;
  logic [MW-1:0] modem_in = '0;
  logic tx_fifo_wr = 0, tx_fifo_empty = 1, tx_shift_empty = 1, rx_fifo_empty = 1;
  logic irq_pending_other = 0, thr_irq_en = 0, thr_irq = 0, tx_dma_en = 0, tx_dma_req = 0;
  logic tx_stat_irq_en = 0, tx_stat_irq = 0, core_irq = 0, core_dma_req = 0, idle_req = 0;
  logic clk_en, wake_irq, idle_ack, wake_out, irq_out, dma_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_pm_ctrl #(.CHAR_CYCLES(CHAR), .MODEM_W(MW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_ir(mode_ir), .cfg_enh_en(cfg_enh_en),
    .cfg_uart_sleep_en(cfg_uart_sleep_en), .cfg_ir_sleep_en(cfg_ir_sleep_en),
    .cfg_div_access(cfg_div_access), .cfg_wake_irq_en(cfg_wake_irq_en),
    .cfg_tx_wake_en(cfg_tx_wake_en), .cfg_wake_mask(cfg_wake_mask), .rx_in(rx_in),
    .modem_in(modem_in), .tx_fifo_wr(tx_fifo_wr), .tx_fifo_empty(tx_fifo_empty),
    .tx_shift_empty(tx_shift_empty), .rx_fifo_empty(rx_fifo_empty),
    .irq_pending_other(irq_pending_other), .thr_irq_en(thr_irq_en), .thr_irq(thr_irq),
    .tx_dma_en(tx_dma_en), .tx_dma_req(tx_dma_req), .tx_stat_irq_en(tx_stat_irq_en),
    .tx_stat_irq(tx_stat_irq), .core_irq(core_irq), .core_dma_req(core_dma_req),
    .idle_req(idle_req), .clk_en(clk_en), .wake_irq(wake_irq), .idle_ack(idle_ack),
    .wake_out(wake_out), .irq_out(irq_out), .dma_out(dma_out)
  );

  // {mode_ir, enh, uart_sleep, ir_sleep, div, txfe, txse, rxfe, pend, expect_asleep}
  localparam logic [9:0] VEC [0:11] = '{
    10'b0110011101, // R1 UART family enabled
    10'b0010011100, // R1 enhanced bit off
    10'b0101011100, // R1 infrared bit ignored in UART family
    10'b1001011101, // R1 infrared family enabled
    10'b1110011100, // R1 UART bits ignored in infrared family
    10'b0110001100, // R2 TX FIFO busy
    10'b0110010100, // R2 TX shift busy
    10'b0110011000, // R2 RX FIFO busy
    10'b0110011110, // R2 interrupt pending
    10'b0110111100, // R10 divisor access, UART
    10'b1001111100, // R10 divisor access, infrared
    10'b1001011110  // R2 interrupt pending, infrared
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic apply_cfg(input logic [9:0] v);
    {mode_ir, cfg_enh_en, cfg_uart_sleep_en, cfg_ir_sleep_en, cfg_div_access,
     tx_fifo_empty, tx_shift_empty, rx_fifo_empty, irq_pending_other} = v[9:1];
  endtask

  task automatic clear_flag();
    cfg_wake_irq_en = 0;
    tick(1);
    cfg_wake_irq_en = 1;
    tick(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    // reset state
    chk("R2 reset clk_en", clk_en, 1'b1);
    chk("R6 reset wake_irq", wake_irq, 1'b0);
    chk("R8 reset idle_ack", idle_ack, 1'b0);
    rst_n = 1'b1;
    tick(CHAR + 10);

    foreach (VEC[i]) begin
      apply_cfg(VEC[i]);
      tick(4);
      chk($sformatf("R1/R2/R10 vector %0d clk_en", i), clk_en, ~VEC[i][0]);
    end

    // R3 and R4: RX pulse wakes, then a full idle character is needed
    apply_cfg(VEC[0]);
    tick(4);
    chk("R2 asleep before rx pulse", clk_en, 1'b0);
    rx_in = 1'b0;
    tick(2);
    chk("R4 rx edge ungates combinationally", clk_en, 1'b1);
    tick(5);
    rx_in = 1'b1;
    tick(10);
    chk("R3 still awake before idle window", clk_en, 1'b1);
    tick(15);
    chk("R3 asleep after idle window", clk_en, 1'b0);

    // R6 wake interrupt via TX FIFO write
    cfg_wake_irq_en = 1;
    tick(1);
    tx_fifo_wr = 1;
    #1;
    chk("R4 tx write ungates combinationally", clk_en, 1'b1);
    tick(1);
    tx_fifo_wr = 0;
    chk("R6 wake_irq set", wake_irq, 1'b1);
    tick(5);
    chk("R6 wake_irq sticky", wake_irq, 1'b1);
    cfg_wake_irq_en = 0;
    tick(1);
    chk("R6 wake_irq cleared by disable", wake_irq, 1'b0);
    cfg_wake_irq_en = 1;
    tick(2);
    chk("R6 wake_irq stays clear", wake_irq, 1'b0);

    // R4 modem change in UART family
    modem_in = 4'b0100;
    tick(4);
    chk("R4 modem change sets wake_irq", wake_irq, 1'b1);
    clear_flag();

    // R5 modem change ignored in infrared family
    apply_cfg(VEC[3]);
    tick(4);
    chk("R5 asleep in infrared", clk_en, 1'b0);
    modem_in = 4'b0000;
    tick(4);
    chk("R5 modem ignored wake_irq", wake_irq, 1'b0);
    chk("R5 modem ignored clk_en", clk_en, 1'b0);

    // R7 TX sources, infrared family
    cfg_tx_wake_en = 1; thr_irq_en = 1; tx_stat_irq_en = 1;
    thr_irq = 1;
    tick(1);
    thr_irq = 0;
    tick(2);
    chk("R7 THR ignored with tx status source", wake_irq, 1'b0);
    tx_stat_irq = 1;
    tick(1);
    tx_stat_irq = 0;
    chk("R7 tx status wakes in infrared", wake_irq, 1'b1);
    clear_flag();

    // R7 TX sources, UART family
    apply_cfg(VEC[0]);
    tx_stat_irq_en = 0; tx_dma_en = 1;
    tick(4);
    thr_irq = 1;
    tick(1);
    thr_irq = 0;
    tick(2);
    chk("R7 THR ignored with DMA enabled", wake_irq, 1'b0);
    tx_dma_req = 1;
    tick(1);
    tx_dma_req = 0;
    chk("R7 TX DMA request wakes", wake_irq, 1'b1);
    clear_flag();
    tx_dma_en = 0;
    thr_irq = 1;
    tick(1);
    thr_irq = 0;
    chk("R7 THR wakes without DMA", wake_irq, 1'b1);
    clear_flag();
    cfg_tx_wake_en = 0; thr_irq_en = 0;

    // R8, R9, R11 idle handshake, sleep disabled
    apply_cfg(VEC[1]);
    cfg_wake_irq_en = 0;
    cfg_wake_mask = 3'b010;
    rx_fifo_empty = 0;
    idle_req = 1;
    tick(3);
    chk("R8 no ack while RX FIFO busy", idle_ack, 1'b0);
    rx_fifo_empty = 1;
    core_irq = 1;
    tick(3);
    chk("R8 no ack while request in flight", idle_ack, 1'b0);
    chk("R8 irq passes before ack", irq_out, 1'b1);
    core_irq = 0;
    tick(1);
    chk("R8 ack once requests clear", idle_ack, 1'b1);
    core_irq = 1; core_dma_req = 1;
    #1;
    chk("R8 irq suppressed while idle", irq_out, 1'b0);
    chk("R8 dma suppressed while idle", dma_out, 1'b0);
    tx_fifo_wr = 1;
    tick(1);
    tx_fifo_wr = 0;
    chk("R11 masked tx write no wake_out", wake_out, 1'b0);
    modem_in = 4'b0001;
    tick(3);
    chk("R11 unmasked modem wake_out pulse", wake_out, 1'b1);
    tick(1);
    chk("R11 wake_out single cycle", wake_out, 1'b0);
    idle_req = 0;
    tick(1);
    chk("R9 ack drops next edge", idle_ack, 1'b0);
    chk("R8 irq restored after idle", irq_out, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule